// File: doc/BRIEF.md
# Interrupt Trigger Conditioner

This block sits between a set of asynchronous interrupt sources and a parent interrupt controller. That controller only understands active-high levels and rising edges. Each channel brings its raw line into the clock domain, can invert it, and then either passes it through as a level or turns chosen transitions into single-cycle pulses. Each channel has three configuration bits. `cfg_edge` selects edge detection instead of level following. `cfg_low` inverts the line before detection, which is how active-low levels and falling edges are served. `cfg_both` makes every transition produce a pulse and overrides the other two bits. The output is always active high.

A change to a channel's configuration is guarded. In the clock cycle after the block sees a new setting, that channel's output is held low. The history sample keeps updating as usual, so a new mode never sees a stale sample and never reports a false edge. Channels are fully independent, and the channel count and synchronizer depth are parameters.

Top module: `trig_cond`

## Requirements
- R1: Each raw input passes through a two-stage synchronizer. A level applied before clock edge k affects `irq_out` from edge k+2 onward, so the output is registered after the second synchronizer stage.
- R2: With `cfg_edge`=0, `cfg_low`=0 and `cfg_both`=0, `irq_out` follows the synchronized input as a level.
- R3: With `cfg_edge`=0, `cfg_low`=1 and `cfg_both`=0, `irq_out` follows the inverse of the synchronized input.
- R4: With `cfg_edge`=1, `cfg_low`=0 and `cfg_both`=0, `irq_out` is high for one cycle after each 0-to-1 transition of the synchronized input. It is low otherwise.
- R5: With `cfg_edge`=1, `cfg_low`=1 and `cfg_both`=0, `irq_out` is high for one cycle after each 1-to-0 transition of the synchronized input.
- R6: With `cfg_both`=1, `irq_out` is high for one cycle after every transition of the synchronized input, whatever the values of `cfg_edge` and `cfg_low`.
- R7: In the edge modes a pulse never lasts more than one cycle, even when the input stays at its new level.
- R8: When a channel's three configuration bits, sampled at an edge, differ from those sampled at the previous edge, that channel's `irq_out` is low after that edge. No edge is reported from a sample taken under the old setting.
- R9: A synchronous active-low reset clears the outputs, the synchronizer, the history and the stored configuration (all three bits read as 0). While `rst_n` is low, `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_raw | input | NUM_CH | Raw asynchronous interrupt lines |
| cfg_edge | input | NUM_CH | Per channel: 1 selects edge detection, 0 selects level |
| cfg_low | input | NUM_CH | Per channel: 1 inverts the line before detection |
| cfg_both | input | NUM_CH | Per channel: 1 pulses on every transition, overriding the other bits |
| irq_out | output | NUM_CH | Active-high conditioned interrupts |

## Verification
The hardest case to reach from the ports is a configuration change that lands while the synchronized input is itself moving. Here a careless design would take an edge from a sample judged under the old mode. The stimulus rewrites every channel's three bits with random values every few cycles, while the raw lines toggle at random. This makes changes coincide with transitions inside the synchronizer in many different phase relations. A reset in the middle of the run, with the lines held high in level mode, confirms that the outputs and the stored configuration return to their cleared state.

// File: rtl/trig_cond_pkg.sv
// Shared types for the interrupt trigger conditioner.
package trig_cond_pkg;

    // Per-channel trigger configuration.
    typedef struct packed {
        logic both;     // pulse on every transition, overrides the rest
        logic low;      // invert the line before detection
        logic edge_en;  // 1: edge detection, 0: level follow
    } trig_cfg_t;

endpackage

// File: rtl/trig_sync.sv
// Multi-stage synchronizer for a vector of asynchronous lines.
// Assumes: STAGES >= 2; synchronous active-low reset clears every stage.
module trig_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the asynchronous lines.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage copies the stage before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

    // R1: the last stage is the previous content of the stage before it.
    assert_sync_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (chain[STAGES-1] == $past(chain[STAGES-2])));

endmodule

// File: rtl/trig_detect.sv
// One channel of trigger conditioning: optional inversion, then either
// level follow, single-edge pulse or any-edge pulse, with a guard that
// holds the output low in the cycle after a configuration change.
// Assumes: smp is already synchronized to clk.
module trig_detect
    import trig_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_cfg_t cfg,
    input  logic      smp,
    output logic      pulse_o
);

    logic      prev_q;
    trig_cfg_t cfg_q;
    logic      pulse_q;
    logic      nxt;
    logic      cur_c;
    logic      prv_c;

    // Compute the output the current sample asks for under cfg.
    always_comb begin
        cur_c = smp ^ cfg.low;
        prv_c = prev_q ^ cfg.low;
        if (cfg.both)         nxt = smp ^ prev_q;
        else if (cfg.edge_en) nxt = cur_c & ~prv_c;
        else                  nxt = cur_c;
    end

    // Keep history and configuration; suppress output on a config change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            cfg_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= smp;
            cfg_q   <= cfg;
            pulse_q <= (cfg != cfg_q) ? 1'b0 : nxt;
        end
    end

    assign pulse_o = pulse_q;

    // R9: reset leaves the output low.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> !pulse_q);

    // R8: a changed configuration never produces an event.
    assert_cfg_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != cfg_q) |=> !pulse_q);

    // R7: single-edge pulses last one cycle.
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.edge_en && !cfg_q.both && pulse_q) |=> !pulse_q);

    // R6: any-edge mode only fires when the sample moved.
    assert_both_needs_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.both && (cfg == cfg_q) && (smp == prev_q)) |=> !pulse_q);

endmodule

// File: rtl/trig_cond.sv
// Top level: synchronizes NUM_CH raw interrupt lines and conditions each
// into an active-high level or pulse for a parent controller.
// Assumes: configuration inputs are synchronous to clk.
module trig_cond
    import trig_cond_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_raw,
    input  logic [NUM_CH-1:0] cfg_edge,
    input  logic [NUM_CH-1:0] cfg_low,
    input  logic [NUM_CH-1:0] cfg_both,
    output logic [NUM_CH-1:0] irq_out
);

    logic [NUM_CH-1:0] smp;

    trig_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_raw),
        .q     (smp)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        trig_cfg_t ch_cfg;
        assign ch_cfg = '{both: cfg_both[c], low: cfg_low[c], edge_en: cfg_edge[c]};

        trig_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (ch_cfg),
            .smp     (smp[c]),
            .pulse_o (irq_out[c])
        );
    end

endmodule

// File: tb/test_trig_cond.sv
module test_trig_cond;
    localparam int NCH = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n = 1'b0;
    logic [NCH-1:0] raw = '0, ce = '0, cl = '0, cb = '0;
    logic [NCH-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Behavioural history of what the design sampled at each edge.
    logic [NCH-1:0] raw_h[$];
    logic [NCH-1:0] e_h[$];
    logic [NCH-1:0] l_h[$];
    logic [NCH-1:0] b_h[$];

    trig_cond #(.NUM_CH(NCH), .SYNC_STAGES(2)) i_trig_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_raw  (raw),
        .cfg_edge (ce),
        .cfg_low  (cl),
        .cfg_both (cb),
        .irq_out  (irq_out)
    );

    task automatic step(input logic r, input logic [NCH-1:0] rv, input logic [NCH-1:0] e,
                        input logic [NCH-1:0] l, input logic [NCH-1:0] b);
        logic [NCH-1:0] expv;
        string tags [NCH];
        int n;
        rst_n = r; raw = rv; ce = e; cl = l; cb = b;
        @(posedge clk);
        raw_h.push_back(r ? rv : '0);
        e_h.push_back(r ? e : '0);
        l_h.push_back(r ? l : '0);
        b_h.push_back(r ? b : '0);
        n = raw_h.size();
        for (int c = 0; c < NCH; c++) begin
            logic cur, prv, a, p;
            cur = raw_h[n-3][c];
            prv = raw_h[n-4][c];
            if (!r) begin
                expv[c] = 1'b0; tags[c] = "R9";
            end else if ({e_h[n-1][c], l_h[n-1][c], b_h[n-1][c]} !=
                         {e_h[n-2][c], l_h[n-2][c], b_h[n-2][c]}) begin
                expv[c] = 1'b0; tags[c] = "R8";
            end else if (b_h[n-1][c]) begin
                expv[c] = cur ^ prv; tags[c] = "R6 R7";
            end else begin
                a = cur ^ l_h[n-1][c];
                p = prv ^ l_h[n-1][c];
                if (e_h[n-1][c]) begin
                    expv[c] = a & ~p;
                    tags[c] = l_h[n-1][c] ? "R5 R7" : "R4 R7";
                end else begin
                    expv[c] = a;
                    tags[c] = l_h[n-1][c] ? "R3 R1" : "R2 R1";
                end
            end
        end
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            n_checks++;
            if (irq_out[c] !== expv[c]) begin
                n_fail++;
                $display("FAIL %s ch%0d: got %b expected %b", tags[c], c, irq_out[c], expv[c]);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            raw_h.push_back('0); e_h.push_back('0); l_h.push_back('0); b_h.push_back('0);
        end
        @(negedge clk);
        // R9: reset with lines high yields zero output.
        for (int i = 0; i < 4; i++) step(1'b0, '1, '0, '0, '0);

        // R1 R2 R3 R4 R5: ch0 level, ch1 inverted level, ch2 rising, ch3 falling.
        for (int i = 0; i < 60; i++)
            step(1'b1, ((i / 5) % 2) ? '1 : '0, 4'b1100, 4'b1010, 4'b0000);
        for (int i = 0; i < 120; i++)
            step(1'b1, NCH'($urandom), 4'b1100, 4'b1010, 4'b0000);
        // R7: held levels after single edges.
        for (int i = 0; i < 30; i++)
            step(1'b1, (i < 12) ? '1 : '0, 4'b1100, 4'b1010, 4'b0000);

        // R6: any-edge mode overrides the other bits.
        for (int i = 0; i < 120; i++)
            step(1'b1, NCH'($urandom), 4'b1100, 4'b1010, 4'b1111);
        for (int i = 0; i < 20; i++)
            step(1'b1, (i % 2) ? '1 : '0, 4'b0101, 4'b0011, 4'b1111);

        // R8: configuration rewritten while lines toggle.
        begin
            logic [NCH-1:0] e, l, b;
            e = '0; l = '0; b = '0;
            for (int i = 0; i < 400; i++) begin
                if (i % 7 == 3) begin
                    e = NCH'($urandom); l = NCH'($urandom); b = NCH'($urandom);
                end
                step(1'b1, NCH'($urandom), e, l, b);
            end
        end

        // R9: reset mid-run with level mode and lines high.
        for (int i = 0; i < 10; i++) step(1'b1, '1, '0, '0, '0);
        for (int i = 0; i < 3; i++)  step(1'b0, '1, '0, '0, '0);
        for (int i = 0; i < 40; i++) step(1'b1, NCH'($urandom), 4'b0110, 4'b0011, 4'b1000);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule